// File: doc/BRIEF.md
# Vector Length Chunk Sequencer

This block walks a loop over an element count of any size, cutting it into chunks no longer than a fixed maximum vector length. For each chunk it offers the execution unit a chunk length and two base addresses, one for the source operand stream and one for the destination operand stream. The chunk length is the smaller of the maximum length and the elements still left. When the execution unit accepts a chunk, the block subtracts the chunk length from the remaining count. It also moves both addresses forward by the chunk length times the element size in bytes. The loop ends when nothing remains.

Because the chunk length is worked out in hardware on every pass, the controlling logic needs no separate setup or tail code. This holds for a count of zero and for counts that are not a multiple of the maximum length. Before the first chunk, a one-cycle configuration step switches on the requested vector register groups and leaves every other group switched off. The length of the most recently accepted chunk stays readable on a port.

Top module: `vl_seq`

## Requirements
- R1: Every offered chunk has `chunk_vl` equal to min(MVL, remaining count), and it is never zero. MVL defaults to 64.
- R2: The first chunk carries `x_base` and `y_base` unchanged. Each later chunk's addresses equal the previous ones plus `chunk_vl << esel`. The `esel` encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes per element.
- R3: The counters and addresses change only in a cycle where `chunk_valid` and `chunk_ready` are both high. While `chunk_valid` is high and `chunk_ready` is low, the chunk outputs hold steady.
- R4: A run issues exactly ceil(n / MVL) chunks, and only the last may have `chunk_vl` < MVL.
- R5: With `n_elems` = 0, no chunk is offered, and `done` is high in the second cycle after `start` is sampled.
- R6: `done` is a one-cycle pulse in the cycle after the last chunk is accepted. While `done` is high, `chunk_valid` is low.
- R7: `last_vl` shows the length of the most recently accepted chunk.
- R8: `grp_en` clears when `start` is sampled and takes the value of `grp_mask` one cycle later. This happens before any chunk is offered. Bits outside the mask stay 0.
- R9: `start` is ignored while `busy` is high, so a run in progress neither restarts nor gains chunks.
- R10: After reset, `busy`, `done`, `chunk_valid`, `grp_en` and `last_vl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| n_elems | input | CNT_W | Element count of the run |
| x_base | input | ADDR_W | Source stream byte address |
| y_base | input | ADDR_W | Destination stream byte address |
| esel | input | 2 | Element size select (1, 2, 4, 8 bytes) |
| grp_mask | input | NGRP | Register groups to enable for the run |
| chunk_valid | output | 1 | A chunk is offered |
| chunk_ready | input | 1 | Execution unit accepts the chunk |
| chunk_vl | output | VL_W | Length of the offered chunk |
| chunk_xaddr | output | ADDR_W | Source address of the chunk |
| chunk_yaddr | output | ADDR_W | Destination address of the chunk |
| last_vl | output | VL_W | Length of the last accepted chunk |
| grp_en | output | NGRP | Enabled register groups |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run complete pulse |

## Verification
Two events can fall in the same cycle: acceptance of the final chunk and a fresh `start` request. The bench provokes this by holding `start` high for a whole run, with `chunk_ready` stalled by a pseudo-random pattern, and releasing it only once `done` is seen. The scoreboard then requires the run to produce exactly its expected chunk list. No chunk may appear after the list is empty, and `busy` must be low a few cycles later.

// File: rtl/vl_seq.sv
module vl_seq #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int MVL    = 64,
  parameter int NGRP   = 8,
  localparam int VL_W  = $clog2(MVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  n_elems,
  input  logic [ADDR_W-1:0] x_base,
  input  logic [ADDR_W-1:0] y_base,
  input  logic [1:0]        esel,
  input  logic [NGRP-1:0]   grp_mask,
  output logic              chunk_valid,
  input  logic              chunk_ready,
  output logic [VL_W-1:0]   chunk_vl,
  output logic [ADDR_W-1:0] chunk_xaddr,
  output logic [ADDR_W-1:0] chunk_yaddr,
  output logic [VL_W-1:0]   last_vl,
  output logic [NGRP-1:0]   grp_en,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {S_IDLE, S_CFG, S_RUN, S_FIN} st_t;

  st_t               st_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] xp_q, yp_q;
  logic [1:0]        es_q;
  logic [NGRP-1:0]   msk_q;

  logic              take;
  logic              last;
  logic [VL_W-1:0]   vl_w;
  logic [ADDR_W-1:0] step_w;

  assign vl_w   = (rem_q >= CNT_W'(MVL)) ? VL_W'(MVL) : rem_q[VL_W-1:0];
  assign step_w = ADDR_W'(vl_w) << es_q;
  assign take   = chunk_valid && chunk_ready;
  assign last   = (rem_q == CNT_W'(vl_w));

  assign chunk_valid = (st_q == S_RUN);
  assign chunk_vl    = vl_w;
  assign chunk_xaddr = xp_q;
  assign chunk_yaddr = yp_q;
  assign busy        = (st_q != S_IDLE);
  assign done        = (st_q == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      rem_q   <= '0;
      xp_q    <= '0;
      yp_q    <= '0;
      es_q    <= '0;
      msk_q   <= '0;
      grp_en  <= '0;
      last_vl <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          rem_q  <= n_elems;
          xp_q   <= x_base;
          yp_q   <= y_base;
          es_q   <= esel;
          msk_q  <= grp_mask;
          grp_en <= '0;
          st_q   <= S_CFG;
        end
        S_CFG: begin
          grp_en <= msk_q;
          st_q   <= (rem_q == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (take) begin
          rem_q   <= rem_q - CNT_W'(vl_w);
          xp_q    <= xp_q + step_w;
          yp_q    <= yp_q + step_w;
          last_vl <= vl_w;
          if (last) st_q <= S_FIN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vl_seq_chk.sv
module vl_seq_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int MVL    = 64,
  parameter int NGRP   = 8,
  localparam int VL_W  = $clog2(MVL + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chunk_valid,
  input logic              chunk_ready,
  input logic [VL_W-1:0]   chunk_vl,
  input logic [ADDR_W-1:0] chunk_xaddr,
  input logic [ADDR_W-1:0] chunk_yaddr,
  input logic [CNT_W-1:0]  rem_q,
  input logic [1:0]        es_q,
  input logic [NGRP-1:0]   msk_q,
  input logic [NGRP-1:0]   grp_en,
  input logic              done
);

  AST_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_vl != '0 && chunk_vl <= VL_W'(MVL))); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chunk_valid && chunk_ready) && chunk_valid) |->
      (chunk_xaddr == $past(chunk_xaddr) + (ADDR_W'($past(chunk_vl)) << es_q) &&
       chunk_yaddr == $past(chunk_yaddr) + (ADDR_W'($past(chunk_vl)) << es_q))); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready) |=>
      (chunk_valid && $stable(chunk_vl) && $stable(chunk_xaddr) &&
       $stable(chunk_yaddr) && $stable(rem_q))); // R3

  AST_SHORT_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && chunk_vl < VL_W'(MVL)) |-> (rem_q == CNT_W'(chunk_vl))); // R4

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chunk_valid); // R6

  AST_CFG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (grp_en == msk_q)); // R8

endmodule

bind vl_seq vl_seq_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .MVL(MVL), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
  .chunk_vl(chunk_vl), .chunk_xaddr(chunk_xaddr), .chunk_yaddr(chunk_yaddr),
  .rem_q(rem_q), .es_q(es_q), .msk_q(msk_q), .grp_en(grp_en), .done(done)
);

// File: tb/tb_vl_seq.sv
`timescale 1ns/1ps
module tb_vl_seq;
  localparam int CNT_W = 16, ADDR_W = 32, MVL = 64, NGRP = 8;
  localparam int VL_W = $clog2(MVL + 1);

  logic clk = 0, rst_n = 0, start = 0, chunk_ready = 0;
  logic [CNT_W-1:0] n_elems = '0;
  logic [ADDR_W-1:0] x_base = '0, y_base = '0;
  logic [1:0] esel = '0;
  logic [NGRP-1:0] grp_mask = '0;
  logic chunk_valid, busy, done;
  logic [VL_W-1:0] chunk_vl, last_vl;
  logic [ADDR_W-1:0] chunk_xaddr, chunk_yaddr;
  logic [NGRP-1:0] grp_en;

  int errors = 0, checks = 0;
  int vq[$];
  logic [ADDR_W-1:0] xq[$], yq[$];
  logic [NGRP-1:0] exp_mask = '0;
  int valid_seen = 0;
  logic rnd_ready = 0;
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  vl_seq dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #2 chunk_ready <= rnd_ready ? lfsr[0] : 1'b1;
  end

  logic pv = 0, pr = 0;
  logic [VL_W-1:0] pvl = '0;
  logic [ADDR_W-1:0] px = '0;
  always @(negedge clk) if (rst_n) begin
    if (pv && !pr)
      chk(chunk_valid && chunk_vl == pvl && chunk_xaddr == px, "R3", "stall hold vl",
          chunk_vl, pvl);
    if (chunk_valid) begin
      valid_seen++;
      if (grp_en != exp_mask)
        chk(0, "R8", "grp_en at chunk", grp_en, exp_mask);
    end
    if (chunk_valid && chunk_ready) begin
      if (vq.size() == 0) chk(0, "R4", "unexpected chunk vl", chunk_vl, 0);
      else begin
        int ev;
        logic [ADDR_W-1:0] ex, ey;
        ev = vq.pop_front(); ex = xq.pop_front(); ey = yq.pop_front();
        chk(chunk_vl == VL_W'(ev), "R1", "chunk vl", chunk_vl, ev);
        chk(chunk_xaddr == ex && chunk_yaddr == ey, "R2", "chunk x addr", chunk_xaddr, ex);
      end
    end
    pv = chunk_valid; pr = chunk_ready; pvl = chunk_vl; px = chunk_xaddr;
  end

  task automatic run(input int n, input logic [ADDR_W-1:0] xb, input logic [ADDR_W-1:0] yb,
                     input logic [1:0] es, input logic [NGRP-1:0] m, input bit hold_start);
    int rem, nchunks, lastv, cyc;
    logic [ADDR_W-1:0] xa, ya;
    rem = n; xa = xb; ya = yb; nchunks = 0; lastv = 0;
    while (rem != 0) begin
      int v;
      v = (rem > MVL) ? MVL : rem;
      vq.push_back(v); xq.push_back(xa); yq.push_back(ya);
      xa += ADDR_W'(v) << es; ya += ADDR_W'(v) << es;
      rem -= v; nchunks++; lastv = v;
    end
    valid_seen = 0;
    @(posedge clk); #2;
    start = 1; n_elems = CNT_W'(n); x_base = xb; y_base = yb; esel = es; grp_mask = m;
    exp_mask = m;
    @(posedge clk); #2;
    if (!hold_start) start = 0;
    n_elems = CNT_W'(n + 5);
    @(negedge clk);
    chk(grp_en == '0 && !chunk_valid, "R8", "grp_en cleared in config cycle", grp_en, 0);
    cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    start = 0;
    chk(done == 1'b1, "R6", "done reached", done, 1);
    chk(!chunk_valid, "R6", "valid low with done", chunk_valid, 0);
    chk(vq.size() == 0, "R4", "chunks left unissued", vq.size(), 0);
    chk(grp_en == m, "R8", "grp_en equals mask", grp_en, m);
    if (n == 0) begin
      chk(cyc == 2, "R5", "zero-count done latency", cyc, 2);
      chk(valid_seen == 0, "R5", "zero-count chunks", valid_seen, 0);
    end else
      chk(last_vl == VL_W'(lastv), "R7", "last_vl", last_vl, lastv);
    @(negedge clk);
    chk(!done, "R6", "done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(!busy && !chunk_valid, "R9", "idle after run", busy, 0);
    vq.delete(); xq.delete(); yq.delete();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !chunk_valid, "R10", "reset outputs", busy, 0);
    chk(grp_en == '0 && last_vl == '0, "R10", "reset grp_en/last_vl", grp_en, 0);
    rst_n = 1;
    run(0, 32'h1000, 32'h2000, 2'd3, 8'h03, 0);
    run(64, 32'h1000, 32'h8000, 2'd3, 8'h03, 0);
    run(1, 32'h0040, 32'h0080, 2'd0, 8'h01, 0);
    run(65, 32'h0100, 32'h0200, 2'd1, 8'h0C, 0);
    rnd_ready = 1;
    run(130, 32'h4000, 32'h6000, 2'd2, 8'hF0, 0);
    run(200, 32'h0000, 32'h9000, 2'd1, 8'h81, 1);
    run(129, 32'hFFF0, 32'h1230, 2'd3, 8'h3C, 1);
    rnd_ready = 0;
    run(3, 32'h10, 32'h20, 2'd2, 8'h01, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule